// File: doc/BRIEF.md
# Picture-Tube Warm-Up Blanking and Cut-Off Status Controller

This block decides when the RGB video outputs may leave the blanked state after the horizontal deflection output is switched on. It also turns digitised cut-off measurements into three calibration status bits. While the tube is cold, the measured cut-off levels fall outside the usable range, so an out-of-range flag stays high and the picture stays dark. When every channel has been inside the range on a measurement and a fixed warm-up guard interval has expired, the flag drops and the outputs unblank. The guard interval keeps a tube that is already warm from flashing a bright picture straight after switch-on.

Each measurement line supplies three cut-off levels in millivolts with a one-cycle valid strobe. The lowest of the three levels drives two alignment aids. One is a window-hit bit, set when the lowest level lies near the mid-rail target. The other is a high-side bit that shows which way the screen-grid voltage should be trimmed. A software-controlled force bit can hold the outputs dark regardless of the flag. The guard interval is counted in millisecond ticks.

Top module: `crt_warmup_blank_ctrl`

## Requirements
- R1: After a synchronous active-low reset: rgb_blank=1, cal_oor=1, cal_win=0, cal_high=0.
- R2: On a valid strobe while hout_en=1, cal_oor becomes 1 on the next cycle if any channel level is below 1500 mV or above 3500 mV. It becomes 0 if all three levels are within 1500..3500 mV inclusive and the guard interval has expired.
- R3: The guard interval expires once INHIBIT_MS (default 500) ms_tick pulses have been counted since hout_en last rose. Before that, cal_oor cannot clear. The count restarts from zero each time hout_en goes low and high again.
- R4: rgb_blank clears on the same cycle that cal_oor falls from 1 to 0. It then stays cleared, even if cal_oor rises again, until hout_en goes low or reset.
- R5: While force_blank=1, rgb_blank=1 combinationally, whatever the flag state.
- R6: On a valid strobe, cal_win becomes 1 when the lowest of the three levels is within 2400..2600 mV inclusive, and 0 otherwise.
- R7: On a valid strobe, cal_high becomes 1 when the lowest level is above 2600 mV, and 0 otherwise. cal_win and cal_high are never both 1.
- R8: Without a valid strobe, all three flags hold their values. Strobes received while hout_en=0 have no effect.
- R9: One cycle after hout_en is seen low, the block is in the R1 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hout_en | input | 1 | Horizontal deflection output enabled |
| meas_vld | input | 1 | One-cycle strobe: cut-off levels are valid |
| cut_r_mv | input | LVL_W | Red channel cut-off level, mV |
| cut_g_mv | input | LVL_W | Green channel cut-off level, mV |
| cut_b_mv | input | LVL_W | Blue channel cut-off level, mV |
| force_blank | input | 1 | Force RGB outputs to the blanking level |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| rgb_blank | output | 1 | RGB blank request |
| cal_oor | output | 1 | Cut-off level out of range |
| cal_win | output | 1 | Lowest level inside alignment window |
| cal_high | output | 1 | Lowest level above upper window edge |

## Verification
On every cycle, the assertions check these properties:
- An out-of-range strobe always raises the flag.
- The flag never drops while the guard interval is running.
- Unblanking coincides with a falling flag.
- Flags hold without a strobe.
- The disabled state is reached one cycle after hout_en drops.
- The guard counter stays bounded.

Only the bench's scenarios can show the following:
- The exact threshold values at the range and window edges.
- That the minimum is taken across all three channels.
- That the guard expires on exactly the INHIBIT_MS-th tick and restarts after re-enable.
- That unblanking is sticky when the flag rises again.

// File: rtl/crt_cal_pkg.sv
// Package: shared defaults and the status flag bundle for the warm-up
// blanking controller. Assumes levels are unsigned millivolt codes.
package crt_cal_pkg;

    parameter int unsigned CAL_LVL_W   = 12;
    parameter int unsigned CAL_NCH     = 3;
    parameter int unsigned CAL_LO_MV   = 1500;
    parameter int unsigned CAL_HI_MV   = 3500;
    parameter int unsigned CAL_TGT_MV  = 2500;
    parameter int unsigned CAL_TOL_MV  = 100;
    parameter int unsigned CAL_GUARD_MS = 500;

    typedef struct packed {
        logic oor;
        logic win;
        logic high;
    } cal_flags_t;

endpackage

// File: rtl/cutoff_eval.sv
// Module: cutoff_eval
// Purely combinational evaluation of one measurement: per-channel range
// check, minimum across channels, window and high-side classification of
// that minimum. Assumes thresholds fit in LVL_W bits and WIN_LO <= WIN_HI.
module cutoff_eval #(
    parameter int unsigned LVL_W  = 12,
    parameter int unsigned NCH    = 3,
    parameter int unsigned LO_MV  = 1500,
    parameter int unsigned HI_MV  = 3500,
    parameter int unsigned WIN_LO = 2400,
    parameter int unsigned WIN_HI = 2600
) (
    input  logic [NCH-1:0][LVL_W-1:0] lvl,
    output crt_cal_pkg::cal_flags_t   eval
);

    localparam logic [LVL_W-1:0] LO_L  = LVL_W'(LO_MV);
    localparam logic [LVL_W-1:0] HI_L  = LVL_W'(HI_MV);
    localparam logic [LVL_W-1:0] WLO_L = LVL_W'(WIN_LO);
    localparam logic [LVL_W-1:0] WHI_L = LVL_W'(WIN_HI);

    logic [NCH-1:0]   ch_bad;
    logic [LVL_W-1:0] run_min [NCH];

    generate
        for (genvar i = 0; i < NCH; i++) begin : g_ch
            // Range check for channel i.
            assign ch_bad[i] = (lvl[i] < LO_L) || (lvl[i] > HI_L);
            if (i == 0) begin : g_first
                assign run_min[i] = lvl[i];
            end else begin : g_rest
                // Running minimum over channels 0..i.
                assign run_min[i] = (lvl[i] < run_min[i-1]) ? lvl[i] : run_min[i-1];
            end
        end
    endgenerate

    // Classify the lowest channel against the alignment window.
    always_comb begin
        eval.oor  = |ch_bad;
        eval.win  = (run_min[NCH-1] >= WLO_L) && (run_min[NCH-1] <= WHI_L);
        eval.high = (run_min[NCH-1] > WHI_L);
    end

endmodule

// File: rtl/warmup_timer.sv
// Module: warmup_timer
// Counts millisecond ticks from the rising of the horizontal enable and
// reports whether the guard interval is still running. Assumes ms_tick is
// a single-cycle pulse; the count saturates at GUARD_MS.
module warmup_timer #(
    parameter int unsigned GUARD_MS = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hout_en,
    input  logic ms_tick,
    output logic guard_on
);

    localparam int unsigned CW = $clog2(GUARD_MS + 1);
    localparam logic [CW-1:0] LIMIT = CW'(GUARD_MS);

    logic [CW-1:0] ms_cnt;

    // Tick counter, cleared while the deflection output is off.
    always_ff @(posedge clk) begin
        if (!rst_n || !hout_en) begin
            ms_cnt <= '0;
        end else if (ms_tick && (ms_cnt != LIMIT)) begin
            ms_cnt <= ms_cnt + 1'b1;
        end
    end

    // Guard interval runs until the limit is reached.
    assign guard_on = (ms_cnt != LIMIT);

    AST_GUARD_CNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        ms_cnt <= LIMIT);  // R3
    AST_GUARD_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        !hout_en |=> guard_on);  // R3

endmodule

// File: rtl/cal_status_ctrl.sv
// Module: cal_status_ctrl
// Holds the three calibration flags and the sticky blank latch. Flags load
// only on a valid strobe while enabled; clearing of the out-of-range flag
// waits for the guard interval; blanking is released on the flag's fall.
module cal_status_ctrl (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    hout_en,
    input  logic                    meas_vld,
    input  logic                    guard_on,
    input  crt_cal_pkg::cal_flags_t eval,
    output crt_cal_pkg::cal_flags_t flags_q,
    output logic                    blank_q
);

    crt_cal_pkg::cal_flags_t flags_d;
    logic                    blank_d;
    logic                    take;

    assign take = hout_en && meas_vld;

    // Next flag state: load on strobe, keep out-of-range set during guard.
    always_comb begin
        flags_d = flags_q;
        if (take) begin
            flags_d.win  = eval.win;
            flags_d.high = eval.high;
            if (eval.oor) begin
                flags_d.oor = 1'b1;
            end else if (!guard_on) begin
                flags_d.oor = 1'b0;
            end
        end
    end

    // Blank latch releases only on a 1->0 transition of the flag.
    always_comb begin
        blank_d = blank_q;
        if (flags_q.oor && !flags_d.oor) begin
            blank_d = 1'b0;
        end
    end

    // State registers; reset or disabled enable returns to the dark state.
    always_ff @(posedge clk) begin
        if (!rst_n || !hout_en) begin
            flags_q <= '{oor: 1'b1, win: 1'b0, high: 1'b0};
            blank_q <= 1'b1;
        end else begin
            flags_q <= flags_d;
            blank_q <= blank_d;
        end
    end

    AST_FAULT_SETS_OOR: assert property (@(posedge clk) disable iff (!rst_n)
        (hout_en && meas_vld && eval.oor) |=> flags_q.oor);  // R2
    AST_NO_CLEAR_IN_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_q.oor && guard_on) |=> flags_q.oor);  // R3
    AST_UNBLANK_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(blank_q) |-> $fell(flags_q.oor));  // R4
    AST_WIN_HIGH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(flags_q.win && flags_q.high));  // R7
    AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (hout_en && !meas_vld) |=> ($stable(flags_q) && $stable(blank_q)));  // R8
    AST_DISABLED_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        !hout_en |=> (flags_q.oor && blank_q && !flags_q.win && !flags_q.high));  // R9

endmodule

// File: rtl/crt_warmup_blank_ctrl.sv
// Module: crt_warmup_blank_ctrl (top)
// Start-up blanking and cut-off status controller for a picture tube.
// Assumes one-cycle meas_vld and ms_tick pulses, synchronous inputs and
// a synchronous active-low reset.
module crt_warmup_blank_ctrl #(
    parameter int unsigned LVL_W    = crt_cal_pkg::CAL_LVL_W,
    parameter int unsigned LO_MV    = crt_cal_pkg::CAL_LO_MV,
    parameter int unsigned HI_MV    = crt_cal_pkg::CAL_HI_MV,
    parameter int unsigned TGT_MV   = crt_cal_pkg::CAL_TGT_MV,
    parameter int unsigned TOL_MV   = crt_cal_pkg::CAL_TOL_MV,
    parameter int unsigned INHIBIT_MS = crt_cal_pkg::CAL_GUARD_MS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hout_en,
    input  logic             meas_vld,
    input  logic [LVL_W-1:0] cut_r_mv,
    input  logic [LVL_W-1:0] cut_g_mv,
    input  logic [LVL_W-1:0] cut_b_mv,
    input  logic             force_blank,
    input  logic             ms_tick,
    output logic             rgb_blank,
    output logic             cal_oor,
    output logic             cal_win,
    output logic             cal_high
);

    localparam int unsigned NCH    = crt_cal_pkg::CAL_NCH;
    localparam int unsigned WIN_LO = TGT_MV - TOL_MV;
    localparam int unsigned WIN_HI = TGT_MV + TOL_MV;

    logic [NCH-1:0][LVL_W-1:0] lvl_bus;
    crt_cal_pkg::cal_flags_t   eval;
    crt_cal_pkg::cal_flags_t   flags_q;
    logic                      guard_on;
    logic                      blank_q;

    assign lvl_bus = {cut_b_mv, cut_g_mv, cut_r_mv};

    cutoff_eval #(
        .LVL_W (LVL_W),
        .NCH   (NCH),
        .LO_MV (LO_MV),
        .HI_MV (HI_MV),
        .WIN_LO(WIN_LO),
        .WIN_HI(WIN_HI)
    ) u_eval (
        .lvl (lvl_bus),
        .eval(eval)
    );

    warmup_timer #(
        .GUARD_MS(INHIBIT_MS)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .hout_en (hout_en),
        .ms_tick (ms_tick),
        .guard_on(guard_on)
    );

    cal_status_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .hout_en (hout_en),
        .meas_vld(meas_vld),
        .guard_on(guard_on),
        .eval    (eval),
        .flags_q (flags_q),
        .blank_q (blank_q)
    );

    // Output drive: forced blanking overrides the warm-up latch.
    always_comb begin
        rgb_blank = blank_q | force_blank;
        cal_oor   = flags_q.oor;
        cal_win   = flags_q.win;
        cal_high  = flags_q.high;
    end

endmodule

// File: tb/crt_warmup_blank_ctrl_tb.sv
module crt_warmup_blank_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int GUARD = 500;
    localparam int NV = 12;

    // Vector table: r, g, b levels and expected oor, win, high (warm state).
    localparam int VR [NV] = '{2500, 1499, 1500, 3501, 2400, 2399, 2600, 2601, 3000, 3000, 3400, 4095};
    localparam int VG [NV] = '{2500, 2500, 3500, 3000, 3000, 3000, 2700, 2700, 2450, 3100, 3500,    0};
    localparam int VB [NV] = '{2500, 2500, 2000, 3000, 3200, 3200, 2800, 2800, 3300, 2550, 3300, 2500};
    localparam bit EO [NV] = '{0, 1, 0, 1, 0, 0, 0, 0, 0, 0, 0, 1};
    localparam bit EW [NV] = '{1, 0, 0, 0, 1, 0, 1, 0, 1, 1, 0, 0};
    localparam bit EH [NV] = '{0, 0, 0, 1, 0, 0, 0, 1, 0, 0, 1, 0};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hout_en = 1'b0;
    logic meas_vld = 1'b0;
    logic [11:0] cut_r_mv = '0;
    logic [11:0] cut_g_mv = '0;
    logic [11:0] cut_b_mv = '0;
    logic force_blank = 1'b0;
    logic ms_tick = 1'b0;
    logic rgb_blank, cal_oor, cal_win, cal_high;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    crt_warmup_blank_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .hout_en(hout_en), .meas_vld(meas_vld),
        .cut_r_mv(cut_r_mv), .cut_g_mv(cut_g_mv), .cut_b_mv(cut_b_mv),
        .force_blank(force_blank), .ms_tick(ms_tick),
        .rgb_blank(rgb_blank), .cal_oor(cal_oor), .cal_win(cal_win), .cal_high(cal_high)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic chk_all(input string req, input logic eb, input logic eo,
                           input logic ew, input logic eh);
        chk(req, "rgb_blank", rgb_blank, eb);
        chk(req, "cal_oor", cal_oor, eo);
        chk(req, "cal_win", cal_win, ew);
        chk(req, "cal_high", cal_high, eh);
    endtask

    // Drive levels at the falling edge, strobe for one cycle, return at falling edge.
    task automatic meas(input int r, input int g, input int b, input bit vld);
        cut_r_mv = 12'(r);
        cut_g_mv = 12'(g);
        cut_b_mv = 12'(b);
        meas_vld = vld;
        @(posedge clk);
        @(negedge clk);
        meas_vld = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin
            ms_tick = 1'b1;
            @(posedge clk);
            @(negedge clk);
            ms_tick = 1'b0;
        end
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        idle(3);
        // R1: reset state
        chk_all("R1", 1'b1, 1'b1, 1'b0, 1'b0);
        rst_n = 1'b1;
        idle(1);
        // R8: strobe while disabled is ignored
        meas(2500, 2500, 2500, 1'b1);
        chk_all("R8", 1'b1, 1'b1, 1'b0, 1'b0);

        hout_en = 1'b1;
        idle(1);
        // R3: good levels during guard keep flag set, window still updates (R6)
        meas(2500, 2500, 2500, 1'b1);
        chk_all("R3", 1'b1, 1'b1, 1'b1, 1'b0);
        ticks(GUARD - 1);
        meas(2500, 2500, 2500, 1'b1);
        chk("R3", "cal_oor one tick early", cal_oor, 1'b1);
        ticks(1);
        idle(1);
        chk("R3", "cal_oor no strobe after expiry", cal_oor, 1'b1);
        // R2/R4: in-range strobe after guard clears flag and unblanks
        meas(2500, 2500, 2500, 1'b1);
        chk("R2", "cal_oor cleared", cal_oor, 1'b0);
        chk("R4", "rgb_blank released", rgb_blank, 1'b0);

        // R5: forced blank
        force_blank = 1'b1;
        #1;
        chk("R5", "rgb_blank forced", rgb_blank, 1'b1);
        idle(1);
        chk("R5", "rgb_blank forced held", rgb_blank, 1'b1);
        force_blank = 1'b0;
        #1;
        chk("R5", "rgb_blank after force off", rgb_blank, 1'b0);

        // R2 R6 R7 R4: vector table in warm state, blank stays released
        for (int i = 0; i < NV; i++) begin
            meas(VR[i], VG[i], VB[i], 1'b1);
            chk("R2", "cal_oor vector", cal_oor, EO[i]);
            chk("R6", "cal_win vector", cal_win, EW[i]);
            chk("R7", "cal_high vector", cal_high, EH[i]);
            chk("R4", "rgb_blank sticky", rgb_blank, 1'b0);
        end

        // R8: levels change without a strobe, flags hold (last vector: 1,0,0)
        meas(2500, 2500, 2500, 1'b0);
        idle(2);
        chk_all("R8", 1'b0, 1'b1, 1'b0, 1'b0);

        // R9: disable returns to dark state
        meas(2700, 2700, 2700, 1'b1);
        chk_all("R7", 1'b0, 1'b0, 1'b0, 1'b1);
        hout_en = 1'b0;
        idle(1);
        chk_all("R9", 1'b1, 1'b1, 1'b0, 1'b0);
        meas(2500, 2500, 2500, 1'b1);
        chk_all("R8", 1'b1, 1'b1, 1'b0, 1'b0);

        // R3: guard restarts on re-enable
        hout_en = 1'b1;
        idle(1);
        ticks(GUARD - 1);
        meas(2500, 2500, 2500, 1'b1);
        chk("R3", "cal_oor guard restarted", cal_oor, 1'b1);
        chk("R3", "rgb_blank guard restarted", rgb_blank, 1'b1);
        ticks(1);
        meas(2500, 2500, 2500, 1'b1);
        chk("R3", "cal_oor after restart expiry", cal_oor, 1'b0);
        chk("R4", "rgb_blank after restart expiry", rgb_blank, 1'b0);

        // R1: reset mid-run
        rst_n = 1'b0;
        idle(1);
        chk_all("R1", 1'b1, 1'b1, 1'b0, 1'b0);
        rst_n = 1'b1;
        idle(1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule